// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction into the equivalent full-width 32-bit instruction word of the base integer set. It is purely combinational, so it can sit between the fetch alignment stage and the main decoder without adding a pipeline cycle. The low two bits of a word choose one of three compressed quadrants. The value 11 marks a word that is already full width, and such a word passes through unchanged. Inside a quadrant, bits [15:13] select the function.

Each compressed form has its own immediate layout, with the bits scrambled, and the block rebuilds the immediate from that layout. Some forms share an opcode slot, and the block applies the priority rules that pick one of them. It also flags every encoding that is reserved, or that belongs to a floating-point or wider-register extension, as illegal. When a word is illegal, the output carries the raw halfword zero-extended, so that a trap handler can record it. Three-bit register fields name registers 8 to 15.

Top module: `cinst_expander`

## Requirements
- R1: With valid_i high and instr_i[1:0] equal to 11, instr_o equals instr_i, is_comp_o is 0 and illegal_o is 0. For any other value of instr_i[1:0], the bits instr_i[31:16] have no effect on the outputs.
- R2: With valid_i low, instr_o, illegal_o and is_comp_o are all zero.
- R3: With valid_i high and instr_i[1:0] not equal to 11, is_comp_o is 1. When the halfword is illegal, illegal_o is 1 and instr_o is {16'h0, instr_i[15:0]}. When the halfword is legal, illegal_o is 0 and instr_o[1:0] is 11.
- R4: Quadrant 0, funct3 000 becomes addi rd'+8, x2, u. In u, bits [5:4] come from [12:11], [9:6] from [10:7], [2] from bit 6 and [3] from bit 5. When u is 0 the halfword is illegal, and this includes the all-zero halfword.
- R5: Quadrant 0, funct3 010 becomes lw, and funct3 110 becomes sw. The base register is [9:7]+8 and the data register is [4:2]+8. The offset is zero-extended: [5:3] from [12:10], [2] from bit 6 and [6] from bit 5.
- R6: Quadrant 1, funct3 000 becomes addi rd, rd, s6. This includes the all-zero-field no-op. Funct3 010 becomes addi rd, x0, s6, and is illegal when rd is 0. s6 is the sign-extended value {bit12, [6:2]}.
- R7: Quadrant 1, funct3 011 with rd equal to 2 becomes addi x2, x2, n. n is sign-extended, with [9] from bit 12, [8:7] from [4:3], [6] from bit 5, [5] from bit 2 and [4] from bit 6, and the halfword is illegal when n is 0. With any other rd, the slot becomes lui rd, s6 (upper bits sign-extended), and is illegal when rd is 0 or s6 is 0.
- R8: Quadrant 1, funct3 100 uses [11:10] to pick the form: 00 becomes srli, 01 becomes srai and 10 becomes andi s6, each on register [9:7]+8. For the two shifts, the shift amount is [6:2], and the halfword is illegal when bit 12 is 1.
- R9: Quadrant 1, funct3 100, [11:10]=11 uses [6:5] to pick sub, xor, or or and (00, 01, 10, 11), in the form rd'=rd' op rs2'. The halfword is illegal when bit 12 is 1.
- R10: Quadrant 1, funct3 001 becomes jal x1 and funct3 101 becomes jal x0. Both use a sign-extended offset: [11] from bit 12, [10] from bit 8, [9:8] from [10:9], [7] from bit 6, [6] from bit 7, [5] from bit 2, [4] from bit 11 and [3:1] from [5:3].
- R11: Quadrant 1, funct3 110 becomes beq rs1', x0, and funct3 111 becomes bne rs1', x0. The offset is sign-extended, with [8] from bit 12, [7:6] from [6:5], [5] from bit 2, [4:3] from [11:10] and [2:1] from [4:3].
- R12: Quadrant 2, funct3 000 becomes slli rd, rd, [6:2], and is illegal when rd is 0 or bit 12 is 1. Funct3 010 becomes lw rd, off(x2), with off [5] from bit 12, [4:2] from [6:4] and [7:6] from [3:2], and is illegal when rd is 0. Funct3 110 becomes sw rs2, off(x2), with off [5:2] from [12:9] and [7:6] from [8:7].
- R13: Quadrant 2, funct3 100 decodes in priority order. With bit 12 at 0: rs2=0 gives jalr x0, 0(rs1), which is illegal when rs1 is 0, and any other rs2 gives add rd, x0, rs2. With bit 12 at 1: rs1=0 and rs2=0 gives ebreak (32'h00100073), rs2=0 gives jalr x1, 0(rs1), and any other value gives add rd, rd, rs2.
- R14: Quadrant 0 funct3 001, 011, 100, 101 and 111, and quadrant 2 funct3 001, 011, 101 and 111, are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Input word is present |
| instr_i | input | 32 | Fetched word; the lower half holds a compressed instruction |
| instr_o | output | 32 | Expanded or passed-through instruction word |
| illegal_o | output | 1 | Compressed halfword is reserved or unsupported |
| is_comp_o | output | 1 | Input was a compressed halfword |

## Verification
The embedded checks are only evaluated when every bit of valid_i and instr_i is known, because a combinational block has no reset to mask the unknown values present at start-up. For the same reason, the checks inside each quadrant decoder look only at the halfword that decoder was given and the word it produced, never at a neighbouring stage. The stimulus always drives fully known values and keeps valid_i low through the bench's reset interval. It changes the input only on a rising edge and reads the outputs on the falling edge, so no check sees an input that is still settling. Every non-passthrough halfword is swept, and each result is compared with an arithmetic encoder built from the requirements.

// File: rtl/cinst_pkg.sv
package cinst_pkg;

   localparam int unsigned FULL_W = 32;
   localparam int unsigned HALF_W = 16;

   localparam logic [6:0] OP_LOAD   = 7'b0000011;
   localparam logic [6:0] OP_STORE  = 7'b0100011;
   localparam logic [6:0] OP_IMM    = 7'b0010011;
   localparam logic [6:0] OP_REG    = 7'b0110011;
   localparam logic [6:0] OP_UPPER  = 7'b0110111;
   localparam logic [6:0] OP_JUMP   = 7'b1101111;
   localparam logic [6:0] OP_JREG   = 7'b1100111;
   localparam logic [6:0] OP_BRANCH = 7'b1100011;

   localparam logic [31:0] WORD_BREAK = 32'h0010_0073;

   typedef struct packed {
      logic        bad;
      logic [31:0] word;
   } xlat_t;

   function automatic logic [31:0] pack_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, OP_REG};
   endfunction

   function automatic logic [31:0] pack_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] pack_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1);
      return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OP_STORE};
   endfunction

   function automatic logic [31:0] pack_b(input logic [12:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3);
      return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OP_BRANCH};
   endfunction

   function automatic logic [31:0] pack_u(input logic [19:0] imm, input logic [4:0] rd);
      return {imm, rd, OP_UPPER};
   endfunction

   function automatic logic [31:0] pack_j(input logic [20:0] imm, input logic [4:0] rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OP_JUMP};
   endfunction

endpackage

// File: rtl/cinst_q0.sv
module cinst_q0
   import cinst_pkg::*;
(
   input  logic [15:2] hw,
   output xlat_t       res
);

   logic [4:0]  rd_p, rs1_p;
   logic [9:0]  sp_off;
   logic [6:0]  w_off;

   assign rd_p   = {2'b01, hw[4:2]};
   assign rs1_p  = {2'b01, hw[9:7]};
   assign sp_off = {hw[10:7], hw[12:11], hw[5], hw[6], 2'b00};
   assign w_off  = {hw[5], hw[12:10], hw[6], 2'b00};

   always_comb begin
      res.bad  = 1'b0;
      res.word = '0;
      unique case (hw[15:13])
         3'b000: begin
            res.bad  = (sp_off == '0);
            res.word = pack_i({2'b00, sp_off}, 5'd2, 3'b000, rd_p, OP_IMM);
         end
         3'b010: res.word = pack_i({5'd0, w_off}, rs1_p, 3'b010, rd_p, OP_LOAD);
         3'b110: res.word = pack_s({5'd0, w_off}, rd_p, rs1_p);
         default: res.bad = 1'b1;
      endcase

      if (!$isunknown(hw) && !res.bad) begin
         if (hw[15:13] != 3'b000) begin
            // R5
            q0_base_reg_chk: assert (res.word[19:18] == 2'b01);
         end else begin
            // R4
            q0_sp_add_chk: assert (res.word[19:15] == 5'd2 && res.word[31:20] != '0
                                   && res.word[21:20] == 2'b00);
         end
      end
   end

endmodule

// File: rtl/cinst_q1.sv
module cinst_q1
   import cinst_pkg::*;
(
   input  logic [15:2] hw,
   output xlat_t       res
);

   logic [4:0]  rd_f, rs1_p, rs2_p;
   logic [11:0] s6;
   logic [11:0] sp_adj;
   logic [20:0] jmp;
   logic [12:0] brn;
   logic [2:0]  alu_f3;

   assign rd_f   = hw[11:7];
   assign rs1_p  = {2'b01, hw[9:7]};
   assign rs2_p  = {2'b01, hw[4:2]};
   assign s6     = {{6{hw[12]}}, hw[12], hw[6:2]};
   assign sp_adj = {{3{hw[12]}}, hw[12], hw[4:3], hw[5], hw[2], hw[6], 4'b0000};
   assign jmp    = {{10{hw[12]}}, hw[8], hw[10:9], hw[6], hw[7], hw[2], hw[11],
                    hw[5:3], 1'b0};
   assign brn    = {{5{hw[12]}}, hw[6:5], hw[2], hw[11:10], hw[4:3], 1'b0};

   always_comb begin
      unique case (hw[6:5])
         2'b00:   alu_f3 = 3'b000;
         2'b01:   alu_f3 = 3'b100;
         2'b10:   alu_f3 = 3'b110;
         default: alu_f3 = 3'b111;
      endcase
   end

   always_comb begin
      res.bad  = 1'b0;
      res.word = '0;
      unique case (hw[15:13])
         3'b000: res.word = pack_i(s6, rd_f, 3'b000, rd_f, OP_IMM);
         3'b001: res.word = pack_j(jmp, 5'd1);
         3'b010: begin
            res.bad  = (rd_f == '0);
            res.word = pack_i(s6, 5'd0, 3'b000, rd_f, OP_IMM);
         end
         3'b011: begin
            if (rd_f == 5'd2) begin
               res.bad  = (sp_adj == '0);
               res.word = pack_i(sp_adj, 5'd2, 3'b000, 5'd2, OP_IMM);
            end else begin
               res.bad  = (rd_f == '0) || (s6 == '0);
               res.word = pack_u({{8{hw[12]}}, s6}, rd_f);
            end
         end
         3'b100: begin
            unique case (hw[11:10])
               2'b00: begin
                  res.bad  = hw[12];
                  res.word = pack_i({7'b0000000, hw[6:2]}, rs1_p, 3'b101, rs1_p, OP_IMM);
               end
               2'b01: begin
                  res.bad  = hw[12];
                  res.word = pack_i({7'b0100000, hw[6:2]}, rs1_p, 3'b101, rs1_p, OP_IMM);
               end
               2'b10: res.word = pack_i(s6, rs1_p, 3'b111, rs1_p, OP_IMM);
               default: begin
                  res.bad  = hw[12];
                  res.word = pack_r((hw[6:5] == 2'b00) ? 7'b0100000 : 7'b0000000,
                                    rs2_p, rs1_p, alu_f3, rs1_p);
               end
            endcase
         end
         3'b101: res.word = pack_j(jmp, 5'd0);
         3'b110: res.word = pack_b(brn, rs1_p, 3'b000);
         default: res.word = pack_b(brn, rs1_p, 3'b001);
      endcase

      if (!$isunknown(hw) && !res.bad) begin
         if (res.word[6:0] == OP_BRANCH) begin
            // R11
            q1_zero_cmp_chk: assert (res.word[24:20] == 5'd0 && res.word[19:18] == 2'b01);
         end
         if (res.word[6:0] == OP_JUMP) begin
            // R10
            q1_link_reg_chk: assert (res.word[11:7] == {4'b0000, ~hw[15]});
         end
      end
   end

endmodule

// File: rtl/cinst_q2.sv
module cinst_q2
   import cinst_pkg::*;
(
   input  logic [15:2] hw,
   output xlat_t       res
);

   logic [4:0]  rd_f, rs2_f;
   logic [11:0] ld_off, st_off;

   assign rd_f   = hw[11:7];
   assign rs2_f  = hw[6:2];
   assign ld_off = {4'b0000, hw[3:2], hw[12], hw[6:4], 2'b00};
   assign st_off = {4'b0000, hw[8:7], hw[12:9], 2'b00};

   always_comb begin
      res.bad  = 1'b0;
      res.word = '0;
      unique case (hw[15:13])
         3'b000: begin
            res.bad  = (rd_f == '0) || hw[12];
            res.word = pack_i({7'b0000000, rs2_f}, rd_f, 3'b001, rd_f, OP_IMM);
         end
         3'b010: begin
            res.bad  = (rd_f == '0);
            res.word = pack_i(ld_off, 5'd2, 3'b010, rd_f, OP_LOAD);
         end
         3'b100: begin
            if (!hw[12]) begin
               if (rs2_f == '0) begin
                  res.bad  = (rd_f == '0);
                  res.word = pack_i(12'd0, rd_f, 3'b000, 5'd0, OP_JREG);
               end else begin
                  res.word = pack_r(7'd0, rs2_f, 5'd0, 3'b000, rd_f);
               end
            end else if (rs2_f == '0 && rd_f == '0) begin
               res.word = WORD_BREAK;
            end else if (rs2_f == '0) begin
               res.word = pack_i(12'd0, rd_f, 3'b000, 5'd1, OP_JREG);
            end else begin
               res.word = pack_r(7'd0, rs2_f, rd_f, 3'b000, rd_f);
            end
         end
         3'b110: res.word = pack_s(st_off, rs2_f, 5'd2);
         default: res.bad = 1'b1;
      endcase

      if (!$isunknown(hw) && !res.bad) begin
         if (res.word[6:0] == OP_JREG) begin
            // R13
            q2_jump_src_chk: assert (res.word[19:15] != 5'd0 && res.word[31:20] == 12'd0);
         end
         if (hw[15:13] == 3'b000 || hw[15:13] == 3'b010) begin
            // R12
            q2_dest_nonzero_chk: assert (res.word[11:7] != 5'd0);
         end
      end
   end

endmodule

// File: rtl/cinst_expander.sv
module cinst_expander
   import cinst_pkg::*;
#(
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned HALF_W       = 16,
   parameter bit          ECHO_ILLEGAL = 1'b1
) (
   input  logic              valid_i,
   input  logic [WORD_W-1:0] instr_i,
   output logic [WORD_W-1:0] instr_o,
   output logic              illegal_o,
   output logic              is_comp_o
);

   localparam int unsigned PAD_W = WORD_W - HALF_W;

   if (WORD_W != FULL_W) begin : g_bad_word_w
      $error("cinst_expander: WORD_W must equal the full instruction width");
   end
   if (HALF_W != cinst_pkg::HALF_W) begin : g_bad_half_w
      $error("cinst_expander: HALF_W must equal the compressed instruction width");
   end

   xlat_t             q0_res, q1_res, q2_res;
   xlat_t             pick;
   logic [WORD_W-1:0] bad_word;

   cinst_q0 u_q0 (.hw(instr_i[15:2]), .res(q0_res));
   cinst_q1 u_q1 (.hw(instr_i[15:2]), .res(q1_res));
   cinst_q2 u_q2 (.hw(instr_i[15:2]), .res(q2_res));

   if (ECHO_ILLEGAL) begin : g_echo
      assign bad_word = {{PAD_W{1'b0}}, instr_i[HALF_W-1:0]};
   end else begin : g_zero
      assign bad_word = '0;
   end

   always_comb begin
      unique case (instr_i[1:0])
         2'b00:   pick = q0_res;
         2'b01:   pick = q1_res;
         default: pick = q2_res;
      endcase
   end

   always_comb begin
      instr_o   = '0;
      illegal_o = 1'b0;
      is_comp_o = 1'b0;
      if (valid_i) begin
         if (instr_i[1:0] == 2'b11) begin
            instr_o = instr_i;
         end else begin
            is_comp_o = 1'b1;
            illegal_o = pick.bad;
            instr_o   = pick.bad ? bad_word : pick.word;
         end
      end

      if (!$isunknown({valid_i, instr_i})) begin
         // R2
         idle_quiet_chk: assert (valid_i || (instr_o == '0 && !illegal_o && !is_comp_o));
         // R3
         bad_is_comp_chk: assert (!illegal_o || is_comp_o);
         // R3
         legal_full_chk: assert (!(is_comp_o && !illegal_o) || instr_o[1:0] == 2'b11);
         // R1
         pass_through_chk: assert (!(valid_i && instr_i[1:0] == 2'b11)
                                   || (instr_o == instr_i && !is_comp_o));
      end
   end

endmodule

// File: tb/cinst_expander_bench.sv
`timescale 1ns/1ps
module cinst_expander_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] instr_o;
   logic        illegal_o, is_comp_o;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   cinst_expander u_cinst_expander (
      .valid_i  (valid_i),
      .instr_i  (instr_i),
      .instr_o  (instr_o),
      .illegal_o(illegal_o),
      .is_comp_o(is_comp_o)
   );

   function automatic int fld(input logic [15:0] c, input int hi, input int lo);
      return int'((c >> lo) & ((16'd1 << (hi - lo + 1)) - 16'd1));
   endfunction

   function automatic int sx(input int v, input int n);
      return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
   endfunction

   function automatic logic [31:0] e_i(input int imm, input int rs1, input int f3,
                                       input int rd, input int op);
      return (32'(imm & 'hfff) << 20) | (32'(rs1) << 15) | (32'(f3) << 12)
           | (32'(rd) << 7) | 32'(op);
   endfunction

   function automatic logic [31:0] e_r(input int f7, input int rs2, input int rs1,
                                       input int f3, input int rd);
      return (32'(f7) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15) | (32'(f3) << 12)
           | (32'(rd) << 7) | 32'h33;
   endfunction

   function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
      return (32'((imm >> 5) & 127) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15)
           | (32'd2 << 12) | (32'(imm & 31) << 7) | 32'h23;
   endfunction

   function automatic logic [31:0] e_b(input int imm, input int rs1, input int f3);
      return (32'((imm >> 12) & 1) << 31) | (32'((imm >> 5) & 63) << 25)
           | (32'(rs1) << 15) | (32'(f3) << 12) | (32'((imm >> 1) & 15) << 8)
           | (32'((imm >> 11) & 1) << 7) | 32'h63;
   endfunction

   function automatic logic [31:0] e_j(input int imm, input int rd);
      return (32'((imm >> 20) & 1) << 31) | (32'((imm >> 1) & 1023) << 21)
           | (32'((imm >> 11) & 1) << 20) | (32'((imm >> 12) & 255) << 12)
           | (32'(rd) << 7) | 32'h6f;
   endfunction

   task automatic ref_exp(input logic [15:0] c, output logic [31:0] w, output bit ill,
                          output string tag);
      int q, f, rd, r2, rdp, r1p, i6, v, sub;
      q   = fld(c, 1, 0);
      f   = fld(c, 15, 13);
      rd  = fld(c, 11, 7);
      r2  = fld(c, 6, 2);
      rdp = fld(c, 4, 2) + 8;
      r1p = fld(c, 9, 7) + 8;
      i6  = sx(fld(c, 12, 12) * 32 + r2, 6);
      ill = 1'b0;
      w   = '0;
      tag = "R14";
      if (q == 0) begin
         if (f == 0) begin
            tag = "R4";
            v = fld(c, 12, 11) * 16 + fld(c, 10, 7) * 64 + fld(c, 6, 6) * 4 + fld(c, 5, 5) * 8;
            ill = (v == 0);
            w = e_i(v, 2, 0, rdp, 'h13);
         end else if (f == 2 || f == 6) begin
            tag = "R5";
            v = fld(c, 12, 10) * 8 + fld(c, 6, 6) * 4 + fld(c, 5, 5) * 64;
            w = (f == 2) ? e_i(v, r1p, 2, rdp, 3) : e_s(v, rdp, r1p);
         end else ill = 1'b1;
      end else if (q == 1) begin
         case (f)
            0: begin tag = "R6"; w = e_i(i6, rd, 0, rd, 'h13); end
            1, 5: begin
               tag = "R10";
               v = sx(fld(c, 12, 12) * 2048 + fld(c, 11, 11) * 16 + fld(c, 10, 9) * 256
                      + fld(c, 8, 8) * 1024 + fld(c, 7, 7) * 64 + fld(c, 6, 6) * 128
                      + fld(c, 5, 3) * 2 + fld(c, 2, 2) * 32, 12);
               w = e_j(v, (f == 1) ? 1 : 0);
            end
            2: begin tag = "R6"; ill = (rd == 0); w = e_i(i6, 0, 0, rd, 'h13); end
            3: begin
               tag = "R7";
               if (rd == 2) begin
                  v = sx(fld(c, 12, 12) * 512 + fld(c, 6, 6) * 16 + fld(c, 5, 5) * 64
                         + fld(c, 4, 3) * 128 + fld(c, 2, 2) * 32, 10);
                  ill = (v == 0);
                  w = e_i(v, 2, 0, 2, 'h13);
               end else begin
                  ill = (rd == 0) || (i6 == 0);
                  w = (32'(i6 & 'hfffff) << 12) | (32'(rd) << 7) | 32'h37;
               end
            end
            4: begin
               sub = fld(c, 11, 10);
               if (sub < 2) begin
                  tag = "R8";
                  ill = fld(c, 12, 12) == 1;
                  w = e_i((sub == 1 ? 'h400 : 0) + r2, r1p, 5, r1p, 'h13);
               end else if (sub == 2) begin
                  tag = "R8";
                  w = e_i(i6, r1p, 7, r1p, 'h13);
               end else begin
                  tag = "R9";
                  ill = fld(c, 12, 12) == 1;
                  v = fld(c, 6, 5);
                  w = e_r((v == 0) ? 'h20 : 0, rdp, r1p,
                          (v == 0) ? 0 : (v == 1) ? 4 : (v == 2) ? 6 : 7, r1p);
               end
            end
            default: begin
               tag = "R11";
               v = sx(fld(c, 12, 12) * 256 + fld(c, 11, 10) * 8 + fld(c, 6, 5) * 64
                      + fld(c, 4, 3) * 2 + fld(c, 2, 2) * 32, 9);
               w = e_b(v, r1p, (f == 6) ? 0 : 1);
            end
         endcase
      end else begin
         if (f == 0) begin
            tag = "R12";
            ill = (rd == 0) || (fld(c, 12, 12) == 1);
            w = e_i(r2, rd, 1, rd, 'h13);
         end else if (f == 2) begin
            tag = "R12";
            ill = (rd == 0);
            w = e_i(fld(c, 6, 4) * 4 + fld(c, 12, 12) * 32 + fld(c, 3, 2) * 64, 2, 2, rd, 3);
         end else if (f == 6) begin
            tag = "R12";
            w = e_s(fld(c, 12, 9) * 4 + fld(c, 8, 7) * 64, r2, 2);
         end else if (f == 4) begin
            tag = "R13";
            if (fld(c, 12, 12) == 0) begin
               if (r2 == 0) begin ill = (rd == 0); w = e_i(0, rd, 0, 0, 'h67); end
               else w = e_r(0, r2, 0, 0, rd);
            end else if (r2 == 0 && rd == 0) w = 32'h0010_0073;
            else if (r2 == 0) w = e_i(0, rd, 0, 1, 'h67);
            else w = e_r(0, r2, rd, 0, rd);
         end else ill = 1'b1;
      end
      if (ill) w = {16'h0, c};
   endtask

   task automatic apply_chk(input logic v, input logic [31:0] x, input logic [31:0] ew,
                            input logic eill, input logic ecmp, input string tag);
      @(posedge clk);
      valid_i = v;
      instr_i = x;
      @(negedge clk);
      total++;
      if (instr_o !== ew || illegal_o !== eill || is_comp_o !== ecmp) begin
         bad++;
         $display("FAIL %s in=%h got w=%h ill=%b cmp=%b exp w=%h ill=%b cmp=%b",
                  tag, x, instr_o, illegal_o, is_comp_o, ew, eill, ecmp);
      end
   endtask

   initial begin
      logic [31:0] w;
      bit          ill;
      string       tag;
      // R2: reset interval with valid low
      repeat (3) apply_chk(1'b0, 32'h1234_5679, 32'h0, 1'b0, 1'b0, "R2 reset");
      rst_n = 1'b1;
      // R1: full-width words pass through untouched
      for (int k = 0; k < 64; k++) begin
         w = (32'(k) * 32'h9E37_79B1) | 32'h3;
         apply_chk(1'b1, w, w, 1'b0, 1'b0, "R1");
      end
      // R2: valid low hides compressed, illegal and full-width inputs
      apply_chk(1'b0, 32'h0000_0000, 32'h0, 1'b0, 1'b0, "R2");
      apply_chk(1'b0, 32'hFFFF_4501, 32'h0, 1'b0, 1'b0, "R2");
      apply_chk(1'b0, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0, "R2");
      // sweep every compressed halfword; upper half alternates to show it is ignored (R1)
      for (int i = 0; i < 65536; i++) begin
         if ((i & 3) != 3) begin
            ref_exp(16'(i), w, ill, tag);
            // R3: illegal halfwords echo, legal ones expand
            if (ill) tag = {"R3 ", tag};
            apply_chk(1'b1, {((i & 4) != 0) ? 16'hA5C3 : 16'h5A3C, 16'(i)}, w, ill, 1'b1, tag);
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired: got running exp finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule